// File: doc/BRIEF.md
# Floating-Point Min/Max Selector

This block picks one of two single-precision floating-point operands without doing any arithmetic. A 2-bit operation code selects one of four comparisons: the larger or smaller operand by signed value, or the operand with the larger or smaller absolute value. The chosen operand leaves the block with every bit unchanged, sign included. It can stand in for a short compare-and-branch sequence inside a sort, a clamp or a search loop.

Ties follow a fixed rule. If the two operands compare equal, the result is always the second operand (`in_b`). This covers equal signed values, equal magnitudes with opposite signs, and +0 against -0. As a result, the outcome depends on the order of the operands. If either operand is a NaN, the block returns `in_b` and raises an invalid flag that travels with that result.

Operands enter and results leave through valid/ready streams, with one register stage in between. The input side accepts a transfer on a clock edge when `in_valid` is high and `in_ready` is high. `in_ready` is high whenever the output register is empty or the consumer is taking its contents in the same cycle. A result that is not taken stays on the outputs, unchanged, until `out_ready` is high.

Top module: `fp_minmax_sel`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0.
- R2: `in_ready` equals (not `out_valid`) or `out_ready`. An input accepted on a clock edge makes `out_valid` 1 after that same edge. While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_invalid` hold their values. If a result is taken and no new input is accepted, `out_valid` drops to 0.
- R3: With op code 0 (signed maximum), the result is `in_a` if `in_a` is strictly greater than `in_b` in signed value, and `in_b` otherwise.
- R4: With op code 1 (signed minimum), the result is `in_a` if `in_a` is strictly less than `in_b` in signed value, and `in_b` otherwise.
- R5: With op code 2 (magnitude maximum), the result is `in_a` if the absolute value of `in_a` is strictly greater than that of `in_b`, and `in_b` otherwise. The chosen operand keeps its sign.
- R6: With op code 3 (magnitude minimum), the result is `in_a` if the absolute value of `in_a` is strictly smaller than that of `in_b`, and `in_b` otherwise. The chosen operand keeps its sign.
- R7: When the operands are equal for the selected comparison, the result is `in_b` bit for bit. This holds for identical words, and for opposite signs with equal magnitude under op codes 2 and 3.
- R8: +0 (0x00000000) and -0 (0x80000000) compare equal under every op code, so the result is the `in_b` zero.
- R9: A NaN operand is one whose exponent field (bits 30:23) is all ones and whose fraction field (bits 22:0) is nonzero. If either operand is a NaN, the result is `in_b` and `out_invalid` is 1. `out_invalid` is 1 with no other result.
- R10: Infinities (exponent all ones, fraction zero) are ordered as the largest magnitudes. The result is always exactly `in_a` or exactly `in_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operand pair and an op code are offered |
| in_ready | output | 1 | The block can accept the offered pair in this cycle |
| in_op | input | 2 | 0 signed max, 1 signed min, 2 magnitude max, 3 magnitude min |
| in_a | input | 32 | First operand, single precision |
| in_b | input | 32 | Second operand; returned on any tie or NaN |
| out_valid | output | 1 | `out_data` and `out_invalid` hold a result |
| out_ready | input | 1 | The consumer takes the result in this cycle |
| out_data | output | 32 | The selected operand, unchanged |
| out_invalid | output | 1 | Set when either operand of this result was a NaN |

## Verification
Each result is due on the outputs one clock edge after its input transfer. It stays there for every later edge at which `out_ready` is low. `in_ready` depends on the current cycle's inputs and the output register's state. The bench drives its inputs just after a falling edge, checks `in_ready` shortly after that, and checks the registered outputs at the next falling edge. A queue-free reference register in the bench advances with the same accept and take rules, so every comparison refers to the transfer that produced the expected value.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

  typedef enum logic [1:0] {
    OP_SMAX = 2'd0,
    OP_SMIN = 2'd1,
    OP_AMAX = 2'd2,
    OP_AMIN = 2'd3
  } fmm_op_e;

  typedef struct packed {
    logic sgn_gt;
    logic sgn_lt;
    logic mag_gt;
    logic mag_lt;
  } fmm_rel_t;

endpackage

// File: rtl/fmm_classify.sv
module fmm_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] val,
  output logic         sign,
  output logic [W-2:0] mag,
  output logic         is_nan,
  output logic         is_zero
);

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;

  assign exp_f   = val[W-2 -: EXP_W];
  assign man_f   = val[MAN_W-1:0];
  assign sign    = val[W-1];
  assign mag     = val[W-2:0];
  assign is_nan  = (&exp_f) && (|man_f);
  assign is_zero = ~|mag;

endmodule

// File: rtl/fmm_compare.sv
module fmm_compare
  import fmm_pkg::*;
#(
  parameter int MAG_W = 31
) (
  input  logic             sign_a,
  input  logic             sign_b,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  input  logic             zero_a,
  input  logic             zero_b,
  output fmm_rel_t         rel
);

  logic m_gt, m_lt;

  assign m_gt = mag_a > mag_b;
  assign m_lt = mag_a < mag_b;

  always_comb begin
    rel.mag_gt = m_gt;
    rel.mag_lt = m_lt;
    if (zero_a && zero_b) begin
      rel.sgn_gt = 1'b0;
      rel.sgn_lt = 1'b0;
    end else if (sign_a != sign_b) begin
      rel.sgn_gt = ~sign_a;
      rel.sgn_lt = sign_a;
    end else if (!sign_a) begin
      rel.sgn_gt = m_gt;
      rel.sgn_lt = m_lt;
    end else begin
      rel.sgn_gt = m_lt;
      rel.sgn_lt = m_gt;
    end
  end

endmodule

// File: rtl/fmm_select.sv
module fmm_select
  import fmm_pkg::*;
#(
  parameter int W = 32
) (
  input  fmm_op_e     op,
  input  fmm_rel_t    rel,
  input  logic        any_nan,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result,
  output logic         invalid
);

  logic a_wins;

  always_comb begin
    unique case (op)
      OP_SMAX: a_wins = rel.sgn_gt;
      OP_SMIN: a_wins = rel.sgn_lt;
      OP_AMAX: a_wins = rel.mag_gt;
      OP_AMIN: a_wins = rel.mag_lt;
      default: a_wins = 1'b0;
    endcase
  end

  assign invalid = any_nan;
  assign result  = (a_wins && !any_nan) ? opnd_a : opnd_b;

endmodule

// File: rtl/fmm_stage.sv
module fmm_stage #(
  parameter int DW = 33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data
);

  logic          v_q;
  logic [DW-1:0] d_q;
  logic          take_in;

  assign s_ready = !v_q || m_ready;
  assign take_in = s_valid && s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
    end else if (take_in) begin
      v_q <= 1'b1;
    end else if (m_ready) begin
      v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= '0;
    end else if (take_in) begin
      d_q <= s_data;
    end
  end

  assign m_valid = v_q;
  assign m_data  = d_q;

endmodule

// File: rtl/fp_minmax_sel.sv
module fp_minmax_sel
  import fmm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_invalid
);

  localparam int NOPS = 2;

  logic [W-1:0] opnd   [NOPS];
  logic         sgn_v  [NOPS];
  logic [W-2:0] mag_v  [NOPS];
  logic         nan_v  [NOPS];
  logic         zero_v [NOPS];

  assign opnd[0] = in_a;
  assign opnd[1] = in_b;

  for (genvar gi = 0; gi < NOPS; gi++) begin : g_cls
    fmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .val    (opnd[gi]),
      .sign   (sgn_v[gi]),
      .mag    (mag_v[gi]),
      .is_nan (nan_v[gi]),
      .is_zero(zero_v[gi])
    );
  end

  fmm_rel_t rel;

  fmm_compare #(.MAG_W(W-1)) u_cmp (
    .sign_a(sgn_v[0]),
    .sign_b(sgn_v[1]),
    .mag_a (mag_v[0]),
    .mag_b (mag_v[1]),
    .zero_a(zero_v[0]),
    .zero_b(zero_v[1]),
    .rel   (rel)
  );

  logic [W-1:0] sel_res;
  logic         sel_inv;

  fmm_select #(.W(W)) u_sel (
    .op     (fmm_op_e'(in_op)),
    .rel    (rel),
    .any_nan(nan_v[0] | nan_v[1]),
    .opnd_a (in_a),
    .opnd_b (in_b),
    .result (sel_res),
    .invalid(sel_inv)
  );

  logic [W:0] stage_out;

  fmm_stage #(.DW(W+1)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_valid(in_valid),
    .s_ready(in_ready),
    .s_data ({sel_inv, sel_res}),
    .m_valid(out_valid),
    .m_ready(out_ready),
    .m_data (stage_out)
  );

  assign out_invalid = stage_out[W];
  assign out_data    = stage_out[W-1:0];

endmodule

// File: rtl/fmm_checker.sv
module fmm_checker #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [1:0]   in_op,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_invalid
);

  logic acc, a_nan, b_nan;
  assign acc   = in_valid && in_ready;
  assign a_nan = (&in_a[W-2 -: EXP_W]) && (|in_a[MAN_W-1:0]);
  assign b_nan = (&in_b[W-2 -: EXP_W]) && (|in_b[MAN_W-1:0]);

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R2

  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R2

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_invalid))); // R2

  AST_TIE_TAKES_B: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_a == in_b) |=> (out_data == $past(in_b))); // R7

  AST_NAN_TAKES_B: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (a_nan || b_nan)) |=> (out_invalid && out_data == $past(in_b))); // R9

  AST_NO_SPURIOUS_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !a_nan && !b_nan) |=> !out_invalid); // R9

  AST_RESULT_IS_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_data == $past(in_a) || out_data == $past(in_b))); // R10

  AST_ZEROS_TAKE_B: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_a[W-2:0] == '0 && in_b[W-2:0] == '0) |=> (out_data == $past(in_b))); // R8

endmodule

bind fp_minmax_sel fmm_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_fmm_chk (.*);

// File: tb/fp_minmax_sel_bench.sv
module fp_minmax_sel_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'd0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        out_invalid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  fp_minmax_sel u_fp_minmax_sel (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_invalid(out_invalid)
  );

  // reference state of the output register
  logic        m_v = 1'b0;
  logic [31:0] m_d = '0;
  logic        m_i = 1'b0;
  string       m_tag = "";

  function automatic bit is_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic longint skey(input logic [31:0] x);
    longint m = longint'(x[30:0]);
    return x[31] ? -m : m;
  endfunction

  function automatic logic [32:0] ref_pick(input logic [31:0] a, input logic [31:0] b,
                                           input logic [1:0] op);
    longint ka, kb;
    bit take_a;
    if (is_nan(a) || is_nan(b)) return {1'b1, b};
    ka = skey(a);
    kb = skey(b);
    case (op)
      2'd0: take_a = ka > kb;
      2'd1: take_a = ka < kb;
      2'd2: take_a = a[30:0] > b[30:0];
      default: take_a = a[30:0] < b[30:0];
    endcase
    return {1'b0, take_a ? a : b};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive after a falling edge, compare at the next falling edge
  task automatic cycle(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op,
                       input bit vin, input bit ordy, input string tag);
    bit acc, take;
    logic [32:0] pk;
    in_a = a; in_b = b; in_op = op; in_valid = vin; out_ready = ordy;
    #1;
    check(in_ready == (!m_v || ordy), "R2", "in_ready", 32'(in_ready), 32'(!m_v || ordy));
    acc  = vin && (!m_v || ordy);
    take = m_v && ordy;
    pk   = ref_pick(a, b, op);
    @(negedge clk);
    if (acc) begin
      m_v = 1'b1; m_d = pk[31:0]; m_i = pk[32]; m_tag = tag;
    end else if (take) begin
      m_v = 1'b0;
    end
    check(out_valid == m_v, "R2", "out_valid", 32'(out_valid), 32'(m_v));
    if (m_v) begin
      check(out_data == m_d, m_tag, "out_data", out_data, m_d);
      check(out_invalid == m_i, "R9", "out_invalid", 32'(out_invalid), 32'(m_i));
      if (acc)
        check(out_data == a || out_data == b, "R10", "operand", out_data, m_d);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'd0);

    // signed max / min
    cycle(32'h40000000, 32'h3F800000, 2'd0, 1, 1, "R3");   // 2 vs 1
    cycle(32'hC0000000, 32'h3F800000, 2'd0, 1, 1, "R3");   // -2 vs 1
    cycle(32'hC0000000, 32'hBF800000, 2'd0, 1, 1, "R3");   // -2 vs -1
    cycle(32'hC0000000, 32'hBF800000, 2'd1, 1, 1, "R4");
    cycle(32'h3F800000, 32'h40000000, 2'd1, 1, 1, "R4");
    // magnitude
    cycle(32'hC0400000, 32'h40000000, 2'd2, 1, 1, "R5");   // -3 vs 2 -> -3
    cycle(32'h3F800000, 32'hC0000000, 2'd2, 1, 1, "R5");
    cycle(32'hBF800000, 32'h40000000, 2'd3, 1, 1, "R6");   // -1 vs 2 -> -1
    cycle(32'h40400000, 32'hBF800000, 2'd3, 1, 1, "R6");
    // ties
    cycle(32'hC0400000, 32'h40400000, 2'd2, 1, 1, "R7");   // -3 vs 3 -> +3
    cycle(32'h40400000, 32'hC0400000, 2'd3, 1, 1, "R7");   // -> -3
    cycle(32'h41200000, 32'h41200000, 2'd0, 1, 1, "R7");
    // signed zero
    for (int op = 0; op < 4; op++) begin
      cycle(32'h00000000, 32'h80000000, op[1:0], 1, 1, "R8");
      cycle(32'h80000000, 32'h00000000, op[1:0], 1, 1, "R8");
    end
    // NaN
    cycle(32'h7FC00000, 32'h3F800000, 2'd0, 1, 1, "R9");
    cycle(32'h3F800000, 32'hFF800001, 2'd3, 1, 1, "R9");
    cycle(32'h7F800000, 32'h7F800001, 2'd1, 1, 1, "R9");
    // infinities
    cycle(32'h7F800000, 32'h7F7FFFFF, 2'd0, 1, 1, "R10");
    cycle(32'hFF800000, 32'h7F7FFFFF, 2'd2, 1, 1, "R10");
    cycle(32'hFF800000, 32'h00000001, 2'd1, 1, 1, "R10");
    // stall: hold result for several cycles
    cycle(32'h40A00000, 32'h40400000, 2'd0, 1, 0, "R2");
    cycle(32'h3F800000, 32'h3F800000, 2'd1, 1, 0, "R2");
    cycle(32'h3F800000, 32'h3F800000, 2'd1, 0, 0, "R2");
    cycle(32'h0, 32'h0, 2'd0, 0, 1, "R2");
    cycle(32'h0, 32'h0, 2'd0, 0, 1, "R2");

    // random traffic with random back-pressure
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ra, rb;
      logic [1:0] rop;
      string tg;
      ra  = $urandom;
      rb  = $urandom;
      rop = 2'($urandom);
      if ($urandom_range(0, 7) == 0) rb = ra;
      if ($urandom_range(0, 7) == 0) rb = {~ra[31], ra[30:0]};
      if ($urandom_range(0, 9) == 0) ra[30:23] = 8'hFF;
      case (rop)
        2'd0: tg = "R3";
        2'd1: tg = "R4";
        2'd2: tg = "R5";
        default: tg = "R6";
      endcase
      cycle(ra, rb, rop, $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, tg);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule